// File: doc/BRIEF.md
# Instruction Queue Doorbell and Error Interrupt Unit

This unit keeps the number of instruction words that software has posted to one instruction queue but that have not yet been fetched. Software announces new work by writing a word count to the doorbell, and the unit adds that count to a pending total. An instruction fetcher outside the unit removes work one whole instruction at a time. Each instruction is eight 64-bit words, so each dispatch removes eight from the total. The total is a 20-bit modular counter. If an addition carries out of it, the sum wraps and an overflow flag is raised. Because of this wrap, software can return the total to zero by adding the two's complement of the current value.

Beside the counter sits a seven-bit sticky status register. Error and mailbox events from neighbouring logic arrive as single-cycle pulses, and each pulse sets its own status bit. Software clears status bits with a write-one-to-clear port. A separate enable mask has its own set port and its own clear port. The unit drives one interrupt line, which is high when any status bit is set and enabled.

Top module: `qdb_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the pending count, status bits, enable bits and `irq` are all zero, and `fetch_req` is low.
- R2: A doorbell write whose value has its three low bits at zero adds that value to `db_count`. The new total is visible on the clock edge that samples the write.
- R3: The count wraps modulo 2^20. A legal write whose sum carries out of 20 bits sets status bit 1 (doorbell overflow). Writing 2^20 minus the current count therefore leaves the count at zero and sets bit 1.
- R4: A doorbell write with any of its three low bits nonzero leaves the count unchanged and sets status bit 4 (engine software error).
- R5: `fetch_req` is high only when all three of these hold: `q_enable` is high, the current count is at least 8, and the count after this cycle's legal doorbell addition (taken modulo 2^20) is also at least 8. A cycle with both `fetch_req` and `fetch_take` high removes 8 from the count, after any addition made in the same cycle.
- R6: While `q_enable` is low, `fetch_req` stays low and `fetch_take` has no effect on the count.
- R7: Each event pulse sets its status bit, and the bit stays set until cleared. The bit positions are: 0 mailbox, 2 instruction read response error, 3 result write response error, 4 engine software error, 5 engine hardware error, 6 translation fault.
- R8: When `sts_clr_en` is high, every status bit whose mask bit is one is cleared and the others are left as they are. An event that sets a bit in the same cycle as its clear wins, so the bit stays set.
- R9: When `ien_set_en` is high, enable bits whose mask bit is one are set. When `ien_clr_en` is high, enable bits whose mask bit is one are cleared. If one bit is both set and cleared in the same cycle, the set wins.
- R10: `irq` equals the OR over all bits of (status AND enable). It updates on the same edge as `sts_out` and `ien_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| q_enable | input | 1 | Queue enable; gates dispatch requests |
| db_wr_en | input | 1 | Doorbell write strobe |
| db_wr_data | input | 20 | Number of words to add to the pending count |
| db_count | output | 20 | Pending word count |
| fetch_req | output | 1 | A whole instruction is available to dispatch |
| fetch_take | input | 1 | Fetcher takes one instruction when `fetch_req` is high |
| evt_mbox | input | 1 | Mailbox event pulse (status bit 0) |
| evt_rd_err | input | 1 | Instruction read response error pulse (bit 2) |
| evt_wr_err | input | 1 | Result write response error pulse (bit 3) |
| evt_sw_err | input | 1 | Engine software error pulse (bit 4) |
| evt_hw_err | input | 1 | Engine hardware error pulse (bit 5) |
| evt_fault | input | 1 | Translation fault pulse (bit 6) |
| sts_clr_en | input | 1 | Status write-one-to-clear strobe |
| sts_clr_mask | input | 7 | Status bits to clear |
| ien_set_en | input | 1 | Enable write-one-to-set strobe |
| ien_set_mask | input | 7 | Enable bits to set |
| ien_clr_en | input | 1 | Enable write-one-to-clear strobe |
| ien_clr_mask | input | 7 | Enable bits to clear |
| sts_out | output | 7 | Sticky status bits |
| ien_out | output | 7 | Interrupt enable bits |
| irq | output | 1 | Combined interrupt |

## Verification
The properties assume that the fetcher raises `fetch_take` only as a response to `fetch_req` in the same cycle. They also assume that the write data, mask and event inputs hold known values whenever their strobes are high. The bench changes every input shortly after a rising edge and holds it for the whole cycle. Pulses last one cycle, and an event input is high only in the cycles a test means it to be. Overflow and wrap cases use word counts chosen so that each sum lands on exactly 2^20 or just past it, which keeps every wrap within the counter's defined modular behaviour.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  // Status and enable bit positions; software decodes these positions.
  localparam int STS_W   = 7;
  localparam int B_MBOX  = 0;
  localparam int B_DOVF  = 1;
  localparam int B_RDERR = 2;
  localparam int B_WRERR = 3;
  localparam int B_SWERR = 4;
  localparam int B_HWERR = 5;
  localparam int B_FAULT = 6;
endpackage

// File: rtl/qdb_counter.sv
module qdb_counter #(
  parameter int CNT_W = 20,
  parameter int GRAIN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             q_en,
  input  logic             take,
  output logic [CNT_W-1:0] count,
  output logic             req,
  output logic             ovf_pulse,
  output logic             bad_pulse
);
  localparam int GRAIN_LG = $clog2(GRAIN);
  localparam logic [CNT_W-1:0] GRAIN_V = CNT_W'(GRAIN);

  logic [CNT_W-1:0] cnt_q;
  logic             legal;
  logic [CNT_W-1:0] addend;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] wrapped;
  logic             consume;

  // Only whole-instruction multiples are accepted.
  assign legal     = wr_en && (wr_data[GRAIN_LG-1:0] == '0);
  assign bad_pulse = wr_en && !legal;
  assign addend    = legal ? wr_data : '0;
  assign sum       = {1'b0, cnt_q} + {1'b0, addend};
  assign wrapped   = sum[CNT_W-1:0];
  assign ovf_pulse = sum[CNT_W];

  // Request is withheld when the same-cycle add would leave too little.
  assign req     = q_en && (cnt_q >= GRAIN_V) && (wrapped >= GRAIN_V);
  assign consume = req && take;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= consume ? (wrapped - GRAIN_V) : wrapped;
  end

  assign count = cnt_q;
endmodule

// File: rtl/qdb_status.sv
module qdb_status #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  input  logic         ien_set_en,
  input  logic [W-1:0] ien_set_mask,
  input  logic         ien_clr_en,
  input  logic [W-1:0] ien_clr_mask,
  output logic [W-1:0] sts,
  output logic [W-1:0] ien,
  output logic         irq
);
  logic [W-1:0] sts_d, ien_d, sts_q, ien_q;
  logic         irq_q;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      // Event set wins over a same-cycle clear.
      assign sts_d[i] = (sts_q[i] && !(clr_en && clr_mask[i])) || set_vec[i];
      assign ien_d[i] = (ien_q[i] && !(ien_clr_en && ien_clr_mask[i])) ||
                        (ien_set_en && ien_set_mask[i]);
      always_ff @(posedge clk) begin
        if (rst) begin
          sts_q[i] <= 1'b0;
          ien_q[i] <= 1'b0;
        end else begin
          sts_q[i] <= sts_d[i];
          ien_q[i] <= ien_d[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(sts_d & ien_d);
  end

  assign sts = sts_q;
  assign ien = ien_q;
  assign irq = irq_q;
endmodule

// File: rtl/qdb_irq_ctrl.sv
module qdb_irq_ctrl #(
  parameter int CNT_W = 20,
  parameter int GRAIN = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     q_enable,
  input  logic                     db_wr_en,
  input  logic [CNT_W-1:0]         db_wr_data,
  output logic [CNT_W-1:0]         db_count,
  output logic                     fetch_req,
  input  logic                     fetch_take,
  input  logic                     evt_mbox,
  input  logic                     evt_rd_err,
  input  logic                     evt_wr_err,
  input  logic                     evt_sw_err,
  input  logic                     evt_hw_err,
  input  logic                     evt_fault,
  input  logic                     sts_clr_en,
  input  logic [qdb_pkg::STS_W-1:0] sts_clr_mask,
  input  logic                     ien_set_en,
  input  logic [qdb_pkg::STS_W-1:0] ien_set_mask,
  input  logic                     ien_clr_en,
  input  logic [qdb_pkg::STS_W-1:0] ien_clr_mask,
  output logic [qdb_pkg::STS_W-1:0] sts_out,
  output logic [qdb_pkg::STS_W-1:0] ien_out,
  output logic                     irq
);
  import qdb_pkg::*;

  logic             ovf_pulse, bad_pulse;
  logic [STS_W-1:0] set_vec;

  qdb_counter #(.CNT_W(CNT_W), .GRAIN(GRAIN)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (db_wr_en),
    .wr_data   (db_wr_data),
    .q_en      (q_enable),
    .take      (fetch_take),
    .count     (db_count),
    .req       (fetch_req),
    .ovf_pulse (ovf_pulse),
    .bad_pulse (bad_pulse)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[B_MBOX]  = evt_mbox;
    set_vec[B_DOVF]  = ovf_pulse;
    set_vec[B_RDERR] = evt_rd_err;
    set_vec[B_WRERR] = evt_wr_err;
    set_vec[B_SWERR] = evt_sw_err || bad_pulse;
    set_vec[B_HWERR] = evt_hw_err;
    set_vec[B_FAULT] = evt_fault;
  end

  qdb_status #(.W(STS_W)) u_sts (
    .clk          (clk),
    .rst          (rst),
    .set_vec      (set_vec),
    .clr_en       (sts_clr_en),
    .clr_mask     (sts_clr_mask),
    .ien_set_en   (ien_set_en),
    .ien_set_mask (ien_set_mask),
    .ien_clr_en   (ien_clr_en),
    .ien_clr_mask (ien_clr_mask),
    .sts          (sts_out),
    .ien          (ien_out),
    .irq          (irq)
  );
endmodule

// File: rtl/qdb_irq_ctrl_chk.sv
module qdb_irq_ctrl_chk #(
  parameter int CNT_W = 20,
  parameter int GRAIN = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      q_enable,
  input logic                      db_wr_en,
  input logic [CNT_W-1:0]          db_wr_data,
  input logic [CNT_W-1:0]          db_count,
  input logic                      fetch_req,
  input logic                      fetch_take,
  input logic                      evt_fault,
  input logic                      sts_clr_en,
  input logic [qdb_pkg::STS_W-1:0] sts_out,
  input logic [qdb_pkg::STS_W-1:0] ien_out,
  input logic                      irq
);
  import qdb_pkg::*;
  localparam int GRAIN_LG = $clog2(GRAIN);
  localparam logic [CNT_W-1:0] GV = CNT_W'(GRAIN);

  logic [CNT_W:0] probe_sum;
  logic           wr_ok, wr_bad;
  assign probe_sum = {1'b0, db_count} + {1'b0, db_wr_data};
  assign wr_ok  = db_wr_en && (db_wr_data[GRAIN_LG-1:0] == '0);
  assign wr_bad = db_wr_en && (db_wr_data[GRAIN_LG-1:0] != '0);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (db_count == '0 && sts_out == '0 && ien_out == '0 && !irq));
  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && probe_sum[CNT_W]) |=> sts_out[B_DOVF]);
  assert_bad_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_bad && !(fetch_req && fetch_take)) |=>
      (db_count == $past(db_count) && sts_out[B_SWERR]));
  assert_req_min_R5: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> (db_count >= GV));
  assert_take_R5: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_take && !db_wr_en) |=> (db_count == $past(db_count) - GV));
  assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !q_enable |-> !fetch_req);
  assert_fault_set_R7: assert property (@(posedge clk) disable iff (rst)
    evt_fault |=> sts_out[B_FAULT]);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !sts_clr_en |=> ((sts_out & $past(sts_out)) == $past(sts_out)));
  assert_irq_R10: assert property (@(posedge clk) disable iff (rst)
    irq == (|(sts_out & ien_out)));
endmodule

bind qdb_irq_ctrl qdb_irq_ctrl_chk #(.CNT_W(CNT_W), .GRAIN(GRAIN)) u_chk (.*);

// File: tb/sim_qdb_irq_ctrl.sv
module sim_qdb_irq_ctrl;
  localparam int CW = 20;
  localparam logic [CW:0] FULL = 21'(1) << CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic q_enable = 0, db_wr_en = 0, fetch_take = 0;
  logic [CW-1:0] db_wr_data = '0;
  logic evt_mbox = 0, evt_rd_err = 0, evt_wr_err = 0, evt_sw_err = 0, evt_hw_err = 0, evt_fault = 0;
  logic sts_clr_en = 0, ien_set_en = 0, ien_clr_en = 0;
  logic [6:0] sts_clr_mask = '0, ien_set_mask = '0, ien_clr_mask = '0;
  logic [CW-1:0] db_count;
  logic fetch_req, irq;
  logic [6:0] sts_out, ien_out;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [CW-1:0] e_cnt = '0;
  logic [6:0] e_sts = '0, e_ien = '0;

  always #4 clk = ~clk;

  qdb_irq_ctrl u0 (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // One cycle: inputs already driven; check request, advance, check state.
  task automatic tick(input string tag);
    logic [CW:0] s;
    logic legal, bad, er;
    logic [6:0] setv;
    #1;
    legal = db_wr_en && (db_wr_data[2:0] == 3'd0);
    bad   = db_wr_en && !legal;
    s     = {1'b0, e_cnt} + (legal ? {1'b0, db_wr_data} : '0);
    er    = q_enable && (e_cnt >= 8) && (s[CW-1:0] >= 8);
    chk(tag, "fetch_req", 32'(fetch_req), 32'(er));
    setv = {evt_fault, evt_hw_err, evt_sw_err | bad, evt_wr_err, evt_rd_err, s[CW], evt_mbox};
    e_cnt = (er && fetch_take) ? s[CW-1:0] - 20'd8 : s[CW-1:0];
    e_sts = (e_sts & ~(sts_clr_en ? sts_clr_mask : 7'd0)) | setv;
    e_ien = (e_ien & ~(ien_clr_en ? ien_clr_mask : 7'd0)) | (ien_set_en ? ien_set_mask : 7'd0);
    @(posedge clk); #1;
    chk(tag, "db_count", 32'(db_count), 32'(e_cnt));
    chk(tag, "sts_out", 32'(sts_out), 32'(e_sts));
    chk(tag, "ien_out", 32'(ien_out), 32'(e_ien));
    chk(tag, "irq", 32'(irq), 32'(|(e_sts & e_ien)));
    db_wr_en = 0; fetch_take = 0; sts_clr_en = 0; ien_set_en = 0; ien_clr_en = 0;
    {evt_mbox, evt_rd_err, evt_wr_err, evt_sw_err, evt_hw_err, evt_fault} = '0;
  endtask

  task automatic wr(input logic [CW-1:0] v, input string tag);
    db_wr_en = 1; db_wr_data = v; tick(tag);
  endtask

  task automatic clr_sts(input logic [6:0] m, input string tag);
    sts_clr_en = 1; sts_clr_mask = m; tick(tag);
  endtask

  task automatic pulse(input int b);
    case (b)
      0: evt_mbox = 1;
      2: evt_rd_err = 1;
      3: evt_wr_err = 1;
      4: evt_sw_err = 1;
      5: evt_hw_err = 1;
      6: evt_fault = 1;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset state
    chk("R1", "db_count", 32'(db_count), 0);
    chk("R1", "sts_out", 32'(sts_out), 0);
    chk("R1", "ien_out", 32'(ien_out), 0);
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "fetch_req", 32'(fetch_req), 0);

    // R2: legal additions sweep, queue disabled
    for (int k = 0; k < 16; k++) wr(20'(8 * k), "R2");
    // R4: every illegal low-bit pattern
    for (int j = 1; j < 8; j++) wr(20'(64 + j), "R4");
    clr_sts(7'h7f, "R8");

    // R3: wrap to zero by complement, then wrap past zero
    wr(20'(FULL - {1'b0, e_cnt}), "R3");
    chk("R3", "count zero", 32'(db_count), 0);
    wr(20'hFFFF8, "R3");
    wr(20'h00010, "R3");
    clr_sts(7'h02, "R3");

    // R6: disabled queue ignores take
    fetch_take = 1; tick("R6");
    // R5: drain by dispatch, with and without same-cycle adds
    q_enable = 1;
    for (int k = 0; k < 4; k++) begin fetch_take = 1; tick("R5"); end
    db_wr_en = 1; db_wr_data = 20'd16; fetch_take = 1; tick("R5");
    for (int k = 0; k < 4; k++) begin fetch_take = 1; tick("R5"); end
    // R5: add that wraps below one instruction suppresses the request
    wr(20'(FULL - {1'b0, e_cnt} + 21'd8), "R5");
    db_wr_en = 1; db_wr_data = 20'hFFFF8; fetch_take = 1; tick("R5");
    chk("R5", "count after suppressed take", 32'(db_count), 0);
    q_enable = 0;
    wr(20'd24, "R6");
    fetch_take = 1; tick("R6");
    clr_sts(7'h7f, "R8");

    // R7 / R8: each event bit; set against same-cycle clear
    for (int b = 0; b < 7; b++) begin
      if (b == 1) continue;
      pulse(b); tick("R7");
      tick("R7");
      pulse(b); sts_clr_en = 1; sts_clr_mask = 7'(1 << b); tick("R8");
      clr_sts(7'(1 << b), "R8");
    end
    // R8: every clear mask against a full status
    for (int p = 0; p < 128; p++) begin
      for (int b = 0; b < 7; b++) pulse(b);
      tick("R7");
      clr_sts(7'(p), "R8");
    end
    // R9 / R10: enable set/clear patterns with collisions
    evt_hw_err = 1; evt_mbox = 1; tick("R10");
    for (int p = 0; p < 128; p++) begin
      ien_set_en = 1; ien_set_mask = 7'(p);
      ien_clr_en = 1; ien_clr_mask = 7'((p * 37 + 11) & 127);
      tick("R9");
      tick("R10");
    end
    ien_clr_en = 1; ien_clr_mask = 7'h7f; tick("R9");
    finish_run();
  end
endmodule